// File: doc/BRIEF.md
# Jumping Horizontal Position Counter

This block produces the horizontal position value of a video display processor, one value per pixel step. The count is not contiguous. Partway through each line it leaps forward to a higher value, runs up to 0x1FF and then wraps to 0x000. Both the point where it leaps and the value it leaps to depend on the line mode. The narrow mode has 32 cells per line and the wide mode has 40.

The counter moves only on clock cycles where the pixel-step enable is high. A new mode request is taken only when the count wraps, so no single line mixes the two sequences. Two flags come with the position: a line-start flag, high while the position is 0x000, and a flag that is high while the position lies in the region after the leap. All outputs are registered.

Top module: `hpos_counter`

## Requirements
- R1: In narrow mode (`wide_sel` latched as 0) the enabled step after position 0x127 gives 0x1D2.
- R2: In wide mode (`wide_sel` latched as 1) the enabled step after position 0x16C gives 0x1C9.
- R3: In either mode the enabled step after 0x1FF gives 0x000. Every other enabled step adds one to the position.
- R4: On a cycle with `pix_en` low, the position and both flags keep their values.
- R5: A narrow line takes 342 enabled steps and a wide line takes 420. In a narrow line, 30 steps have positions in 0x10A..0x127 and 46 steps have positions in 0x1D2..0x1FF. At 10 master clocks per step, a narrow line spans 3420 master clocks.
- R6: The value of `wide_sel` is latched only on the enabled step that wraps 0x1FF to 0x000. It governs the whole of the line that follows.
- R7: `line_start` is high exactly while the position is 0x000.
- R8: `past_jump` is high exactly while the position is at or above the leap target of the line's mode: 0x1D2 in narrow mode, 0x1C9 in wide mode.
- R9: A synchronous active-high reset sets the position to 0x000, selects narrow mode, sets `line_start` high and sets `past_jump` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pix_en | input | 1 | Pixel-step enable |
| wide_sel | input | 1 | Requested line mode: 1 for wide, 0 for narrow |
| hpos | output | 9 | Horizontal position |
| line_start | output | 1 | High while the position is 0x000 |
| past_jump | output | 1 | High while the position is past the leap |

## Verification
Every result of an enabled step appears on the same clock edge that samples `pix_en`. The position, both flags and the latched mode all change together, one register away from the inputs. The bench therefore drives inputs on the falling edge and compares all outputs one nanosecond after the next rising edge against its own arithmetic model. A mode request made in the middle of a line shows no effect until the first edge after the wrap. The bench checks this by confirming that the old leap still occurs and the new leap follows only in the next line.

// File: rtl/hpos_pkg.sv
package hpos_pkg;
  typedef enum logic {
    LINE_NARROW = 1'b0,
    LINE_WIDE   = 1'b1
  } line_mode_e;
endpackage

// File: rtl/hpos_mode_hold.sv
module hpos_mode_hold
  import hpos_pkg::*;
#(
  parameter int CNT_W = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pix_en,
  input  logic             wide_sel,
  input  logic [CNT_W-1:0] count,
  output line_mode_e       mode
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic at_wrap;
  assign at_wrap = pix_en && (count == CNT_MAX);

  always_ff @(posedge clk) begin
    if (rst)          mode <= LINE_NARROW;
    else if (at_wrap) mode <= wide_sel ? LINE_WIDE : LINE_NARROW;
  end

  // R6: the mode moves only on the wrapping step
  p_mode_hold_r6: assert property (@(posedge clk) disable iff (rst)
    !(pix_en && count == CNT_MAX) |=> $stable(mode));
endmodule

// File: rtl/hpos_seq.sv
module hpos_seq
  import hpos_pkg::*;
#(
  parameter int                CNT_W    = 9,
  parameter logic [CNT_W-1:0]  NAR_FROM = 9'h127,
  parameter logic [CNT_W-1:0]  NAR_TO   = 9'h1D2,
  parameter logic [CNT_W-1:0]  WID_FROM = 9'h16C,
  parameter logic [CNT_W-1:0]  WID_TO   = 9'h1C9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pix_en,
  input  line_mode_e       mode,
  output logic [CNT_W-1:0] count,
  output logic             line_start,
  output logic             past_jump
);
  localparam logic [CNT_W-1:0] CNT_MAX  = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] CNT_ZERO = '0;

  logic [CNT_W-1:0] leap_from, leap_to, nxt;

  always_comb begin
    leap_from = (mode == LINE_WIDE) ? WID_FROM : NAR_FROM;
    leap_to   = (mode == LINE_WIDE) ? WID_TO   : NAR_TO;
    if (count == CNT_MAX)        nxt = CNT_ZERO;
    else if (count == leap_from) nxt = leap_to;
    else                         nxt = count + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      count      <= CNT_ZERO;
      line_start <= 1'b1;
      past_jump  <= 1'b0;
    end else if (pix_en) begin
      count      <= nxt;
      line_start <= (nxt == CNT_ZERO);
      past_jump  <= (nxt >= leap_to) && (nxt != CNT_ZERO);
    end
  end

  p_leap_narrow_r1: assert property (@(posedge clk) disable iff (rst)
    (pix_en && mode == LINE_NARROW && count == NAR_FROM) |=> count == NAR_TO);
  p_leap_wide_r2: assert property (@(posedge clk) disable iff (rst)
    (pix_en && mode == LINE_WIDE && count == WID_FROM) |=> count == WID_TO);
  p_wrap_r3: assert property (@(posedge clk) disable iff (rst)
    (pix_en && count == CNT_MAX) |=> count == CNT_ZERO);
  p_hold_r4: assert property (@(posedge clk) disable iff (rst)
    !pix_en |=> ($stable(count) && $stable(line_start) && $stable(past_jump)));
  p_start_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(line_start) |-> (count == CNT_ZERO && $past(count) == CNT_MAX));
  p_past_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(past_jump) |-> ($past(count) == leap_from && count == leap_to));
endmodule

// File: rtl/hpos_counter.sv
module hpos_counter
  import hpos_pkg::*;
#(
  parameter int               CNT_W    = 9,
  parameter logic [CNT_W-1:0] NAR_FROM = 9'h127,
  parameter logic [CNT_W-1:0] NAR_TO   = 9'h1D2,
  parameter logic [CNT_W-1:0] WID_FROM = 9'h16C,
  parameter logic [CNT_W-1:0] WID_TO   = 9'h1C9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pix_en,
  input  logic             wide_sel,
  output logic [CNT_W-1:0] hpos,
  output logic             line_start,
  output logic             past_jump
);
  line_mode_e mode;

  hpos_mode_hold #(.CNT_W(CNT_W)) u_mode (
    .clk(clk), .rst(rst), .pix_en(pix_en), .wide_sel(wide_sel),
    .count(hpos), .mode(mode)
  );

  hpos_seq #(
    .CNT_W(CNT_W), .NAR_FROM(NAR_FROM), .NAR_TO(NAR_TO),
    .WID_FROM(WID_FROM), .WID_TO(WID_TO)
  ) u_seq (
    .clk(clk), .rst(rst), .pix_en(pix_en), .mode(mode),
    .count(hpos), .line_start(line_start), .past_jump(past_jump)
  );

  // R9: out of reset the flags agree with position zero
  p_reset_r9: assert property (@(posedge clk)
    $past(rst) |-> (hpos == '0 && line_start && !past_jump && mode == LINE_NARROW));
endmodule

// File: tb/hpos_counter_tb.sv
module hpos_counter_tb;
  logic clk = 1'b0, rst = 1'b1, pix_en = 1'b0, wide_sel = 1'b0;
  logic [8:0] hpos;
  logic line_start, past_jump;
  int checks = 0, fails = 0, cyc = 0;
  int exp_cnt = 0;
  bit exp_wide = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  hpos_counter u_dut (
    .clk(clk), .rst(rst), .pix_en(pix_en), .wide_sel(wide_sel),
    .hpos(hpos), .line_start(line_start), .past_jump(past_jump)
  );

  task automatic chk(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  function automatic int leap_src(bit w); return w ? 'h16C : 'h127; endfunction
  function automatic int leap_dst(bit w); return w ? 'h1C9 : 'h1D2; endfunction

  // one clock; model advances on enabled steps; compares all outputs
  task automatic step(input bit en, input string tag);
    @(negedge clk);
    pix_en = en;
    @(posedge clk);
    #1;
    if (en) begin
      if (exp_cnt == 'h1FF) begin exp_cnt = 0; exp_wide = wide_sel; end
      else if (exp_cnt == leap_src(exp_wide)) exp_cnt = leap_dst(exp_wide);
      else exp_cnt++;
    end
    chk(tag, int'(hpos), exp_cnt);
    chk("R7", int'(line_start), int'(exp_cnt == 0));
    chk("R8", int'(past_jump), int'(exp_cnt >= leap_dst(exp_wide)));
  endtask

  // runs one full line with enable high; returns step counts
  task automatic run_line(input string tag, output int n, output int n_a, output int n_b);
    n = 0; n_a = 0; n_b = 0;
    do begin
      if (exp_cnt >= 'h10A && exp_cnt <= 'h127) n_a++;
      if (exp_cnt >= 'h1D2) n_b++;
      step(1'b1, tag);
      n++;
    end while (exp_cnt != 0 && n < 1000);
  endtask

  initial begin
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        fails++;
        $display("FAIL watchdog: got %0d expected <100000 cycles", cyc);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
      end
    end
  end

  initial begin
    int n, a, b;
    bit prev_start;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    // R9 reset state
    chk("R9", int'(hpos), 0);
    chk("R9", int'(line_start), 1);
    chk("R9", int'(past_jump), 0);

    // narrow lines: R1 R3 R5
    run_line("R1", n, a, b);
    chk("R5", n, 342);
    chk("R5", a, 30);
    chk("R5", b, 46);
    run_line("R3", n, a, b);
    chk("R5", n, 342);

    // request wide mid-line; current line must stay narrow (R6)
    repeat (100) step(1'b1, "R3");
    wide_sel = 1'b1;
    run_line("R6", n, a, b);
    chk("R6", n, 342 - 100);
    // now wide: R2
    run_line("R2", n, a, b);
    chk("R5", n, 420);

    // R4: sparse enable over a wide line
    wide_sel = 1'b0;
    n = 0;
    do begin
      step(((n % 3) != 1), "R4");
      n++;
    end while (!(exp_cnt == 0 && n > 10) && n < 3000);
    chk("R4", int'(hpos), 0);
    // back to narrow after wrap, with some stalls at line start
    prev_start = line_start;
    repeat (5) step(1'b0, "R4");
    chk("R4", int'(line_start), int'(prev_start));
    run_line("R6", n, a, b);
    chk("R5", n, 342);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule